// File: doc/BRIEF.md
# Beacon Timer Spacing Checker

The block checks whether three periodic 16-bit beacon-schedule timers still sit at their intended distances from one another. Each timer moves forward by the beacon interval when local time reaches its value. Because the timers are updated one at a time and wrap at 16 bits, a snapshot can catch one timer already advanced while its partner is not, or one timer wrapped past zero. The check accepts all of these cases as healthy. It flags only a real drift in spacing.

Two pairs are examined on every check strobe. In the first pair, the announcement-window end timer must lie one time unit after the next-beacon timer. In the second pair, the next-beacon timer must lie a configurable response window after the beacon-DMA timer. The DMA timer arrives in eighth-unit resolution, so its three low bits are dropped first. The registered verdict and a one-cycle valid pulse appear on the clock edge after the strobe. Monitoring software uses the fail verdict to decide whether the timers need reprogramming.

Top module: `bcn_timer_win_chk`

## Requirements
- R1: While rst_ni is low, and after reset until the first strobe, valid_o and pass_o are 0.
- R2: valid_o is 1 in exactly the cycle after a cycle with check_i = 1, and 0 in every other cycle.
- R3: pass_o is updated only at the edge that samples check_i = 1. Otherwise it keeps its value.
- R4: A pair whose later timer equals the earlier timer plus its window, without wraparound, passes.
- R5: A pair passes when the earlier timer has already advanced, so that earlier minus later equals interval_i minus the window. The same difference checked against a different interval fails.
- R6: A pair passes when the earlier timer has advanced and wrapped, so that (earlier + 65536) minus later equals interval_i minus the window.
- R7: A pair passes when the later timer has wrapped past zero, so that (later + 65536) minus earlier equals the window.
- R8: The DMA timer value is dma_raw_i shifted right by 3. Bits [2:0] have no effect on the verdict, and the next-beacon timer must exceed that value by DMA_WIN (default 2).
- R9: pass_o is 1 only when both the end-timer pair (window 1) and the DMA pair pass. If either pair fails, pass_o is 0.
- R10: A pair whose spacing matches none of the four relations fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| check_i | input | 1 | Check strobe; the timers are sampled in this cycle |
| next_bcn_i | input | 16 | Next-beacon timer value |
| atim_end_i | input | 16 | Announcement-window end timer value |
| dma_raw_i | input | 19 | Beacon-DMA timer in eighth-unit resolution |
| interval_i | input | 16 | Beacon interval |
| pass_o | output | 1 | 1 when both pairs hold their spacing |
| valid_o | output | 1 | One-cycle pulse marking a new verdict |

## Verification
Separate vectors place each pair in one relation at a time: direct spacing, earlier timer advanced, earlier timer advanced and wrapped, and later timer wrapped. This shows that each relation is recognised on its own. A second group breaks one pair, then the other pair, then both, so that the AND of the two pair results is exercised. The interval is changed under an otherwise passing snapshot to show that the advanced-timer relation really depends on it. The DMA value is driven with different low bits, and then shifted by one unit, to show that the shift is applied rather than the bits being masked.

// File: rtl/bcn_win_pkg.sv
package bcn_win_pkg;
  localparam int unsigned TMR_W_DEF  = 16;
  localparam int unsigned FRAC_W_DEF = 3;
  localparam int unsigned ATIM_WIN   = 1;
  localparam int unsigned DMA_WIN_DEF = 2;

  typedef struct packed {
    logic atim_ok;
    logic dma_ok;
  } pair_res_t;
endpackage

// File: rtl/bcn_dma_align.sv
module bcn_dma_align #(
  parameter int unsigned TMR_W  = 16,
  parameter int unsigned FRAC_W = 3
) (
  input  logic [TMR_W+FRAC_W-1:0] raw_i,
  output logic [TMR_W-1:0]        tu_o
);
  // drop sub-unit fraction bits
  assign tu_o = raw_i[TMR_W+FRAC_W-1:FRAC_W];
endmodule

// File: rtl/bcn_win_pair.sv
module bcn_win_pair #(
  parameter int unsigned TMR_W = 16,
  parameter int unsigned WIN   = 1
) (
  input  logic [TMR_W-1:0] a_i,
  input  logic [TMR_W-1:0] b_i,
  input  logic [TMR_W-1:0] interval_i,
  output logic             ok_o
);
  localparam int unsigned AW = TMR_W + 2;

  logic signed [AW-1:0] a_s, b_s, aw_s, bw_s, win_s, iw_s;
  logic fwd, adv, adv_wrap, b_wrap;

  always_comb begin
    a_s   = $signed({2'b00, a_i});
    b_s   = $signed({2'b00, b_i});
    aw_s  = $signed({2'b01, a_i});
    bw_s  = $signed({2'b01, b_i});
    win_s = $signed(AW'(WIN));
    iw_s  = $signed({2'b00, interval_i}) - win_s;
  end

  assign fwd      = (b_s  - a_s) == win_s;
  assign adv      = (a_s  - b_s) == iw_s;
  assign adv_wrap = (aw_s - b_s) == iw_s;
  assign b_wrap   = (bw_s - a_s) == win_s;
  assign ok_o     = fwd | adv | adv_wrap | b_wrap;

  // modular forward spacing must always be accepted
  always_comb begin
    if (b_i == TMR_W'(a_i + TMR_W'(WIN)))
      AST_FWD_WRAP: assert (ok_o) else $error("forward spacing rejected"); // R7
  end
endmodule

// File: rtl/bcn_res_reg.sv
module bcn_res_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic check_i,
  input  logic ok_i,
  output logic pass_o,
  output logic valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= check_i;
      if (check_i) pass_o <= ok_i;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_i |=> valid_o); // R2
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !check_i |=> !valid_o); // R2
  AST_PASS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !check_i |=> $stable(pass_o)); // R3
endmodule

// File: rtl/bcn_timer_win_chk.sv
module bcn_timer_win_chk
  import bcn_win_pkg::*;
#(
  parameter int unsigned TMR_W   = TMR_W_DEF,
  parameter int unsigned FRAC_W  = FRAC_W_DEF,
  parameter int unsigned DMA_WIN = DMA_WIN_DEF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    check_i,
  input  logic [TMR_W-1:0]        next_bcn_i,
  input  logic [TMR_W-1:0]        atim_end_i,
  input  logic [TMR_W+FRAC_W-1:0] dma_raw_i,
  input  logic [TMR_W-1:0]        interval_i,
  output logic                    pass_o,
  output logic                    valid_o
);
  logic [TMR_W-1:0] dma_tu;
  pair_res_t        res;

  bcn_dma_align #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_align (
    .raw_i (dma_raw_i),
    .tu_o  (dma_tu)
  );

  // next beacon -> window end
  bcn_win_pair #(.TMR_W(TMR_W), .WIN(ATIM_WIN)) u_atim_pair (
    .a_i        (next_bcn_i),
    .b_i        (atim_end_i),
    .interval_i (interval_i),
    .ok_o       (res.atim_ok)
  );

  // dma -> next beacon
  bcn_win_pair #(.TMR_W(TMR_W), .WIN(DMA_WIN)) u_dma_pair (
    .a_i        (dma_tu),
    .b_i        (next_bcn_i),
    .interval_i (interval_i),
    .ok_o       (res.dma_ok)
  );

  bcn_res_reg u_res (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .check_i (check_i),
    .ok_i    (res.atim_ok & res.dma_ok),
    .pass_o  (pass_o),
    .valid_o (valid_o)
  );

  AST_FAIL_ANY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (check_i && !(res.atim_ok && res.dma_ok)) |=> !pass_o); // R9
  AST_PASS_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (check_i && res.atim_ok && res.dma_ok) |=> pass_o); // R9
endmodule

// File: tb/bcn_timer_win_chk_test.sv
module bcn_timer_win_chk_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        check = 1'b0;
  logic [15:0] nbtt = '0, atim = '0, intv = '0;
  logic [18:0] draw = '0;
  logic        pass, valid;

  int checks = 0;
  int errors = 0;
  bit exp_q[$];
  string tag_q[$];
  logic chk_d = 1'b0;
  bit last_exp = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bcn_timer_win_chk uut (
    .clk_i(clk), .rst_ni(rst_n), .check_i(check),
    .next_bcn_i(nbtt), .atim_end_i(atim), .dma_raw_i(draw),
    .interval_i(intv), .pass_o(pass), .valid_o(valid)
  );

  task automatic report(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: pushes expected verdict, then strobes
  task automatic run(input logic [15:0] n, input logic [15:0] a, input logic [18:0] d,
                     input logic [15:0] i, input bit exp, input string req);
    @(negedge clk);
    nbtt = n; atim = a; draw = d; intv = i; check = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(req);
    last_exp = exp;
    @(negedge clk);
    check = 1'b0;
    @(negedge clk);
    @(negedge clk);
    report(pass === last_exp, {req, " R3 hold"}, pass, last_exp);
  endtask

  always @(posedge clk) chk_d <= check;

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      report(valid === chk_d, "R2 valid timing", valid, chk_d);
      if (valid === 1'b1) begin
        if (exp_q.size() == 0) report(1'b0, "R2 spurious result", 1, 0);
        else begin
          bit e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          report(pass === e, t, pass, e);
        end
      end
    end
  end

  initial begin
    #10000;
    if (!done) begin
      report(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    report(valid === 1'b0 && pass === 1'b0, "R1 in reset", {valid, pass}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    report(valid === 1'b0 && pass === 1'b0, "R1 after reset", {valid, pass}, 0);

    // R4 direct spacing, R8 low bits nonzero
    run(16'd1000, 16'd1001, 19'(998*8+5), 16'd100, 1'b1, "R4 direct");
    // R5 next beacon advanced past window end
    run(16'd1100, 16'd1001, 19'(1098*8), 16'd100, 1'b1, "R5 nbtt advanced");
    // R5 dma advanced past next beacon
    run(16'd1100, 16'd1101, 19'(1198*8+3), 16'd100, 1'b1, "R5 dma advanced");
    // R5 same snapshot, other interval
    run(16'd1100, 16'd1001, 19'(1098*8), 16'd200, 1'b0, "R5 wrong interval");
    // R6 earlier timer advanced and wrapped
    run(16'h0010, 16'hFFAD, 19'(16'h000E*8), 16'd100, 1'b1, "R6 adv wrap");
    // R7 later timer wrapped
    run(16'hFFFF, 16'h0000, 19'(16'hFFFD*8), 16'd100, 1'b1, "R7 atim wrap");
    run(16'h0001, 16'h0002, 19'(16'hFFFF*8+1), 16'd100, 1'b1, "R7 nbtt wrap");
    // R8 fraction bits ignored, shift applied
    run(16'd1000, 16'd1001, 19'(998*8+7), 16'd100, 1'b1, "R8 frac 7");
    run(16'd1000, 16'd1001, 19'(998*8), 16'd100, 1'b1, "R8 frac 0");
    run(16'd1000, 16'd1001, 19'(999*8), 16'd100, 1'b0, "R8 shifted by one");
    // R9 / R10 broken pairs
    run(16'd1000, 16'd1002, 19'(998*8), 16'd100, 1'b0, "R9 atim bad R10");
    run(16'd1000, 16'd1001, 19'(997*8), 16'd100, 1'b0, "R9 dma bad R10");
    run(16'd1000, 16'd1003, 19'(990*8), 16'd100, 1'b0, "R9 both bad");
    run(16'd5000, 16'd5001, 19'(4998*8), 16'd300, 1'b1, "R9 both good");

    repeat (3) @(negedge clk);
    report(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule